// File: doc/BRIEF.md
# Three-Phase Hall Commutation and PWM Gate

This block turns three Hall comparator bits into the switch enables of a three-phase half-bridge for a brushless motor. For each rotor position it picks one phase to source current (high-side switch on) and one phase to sink it (low-side switch on). The third phase is left floating. A direction input swaps the position map so the motor turns the other way. A run/stop input gates every switch.

Drive power is set by chopping only the low-side switch, against a free-running PWM carrier count. The chosen high-side switch stays on for the whole period. An overcurrent comparator flag cuts the low-side on-time for the rest of the current carrier period. No other compensation is applied. The direction input is taken only while the motor is stopped, so a reversal cannot happen while the motor spins.

All outputs are registered. A change on any input shows at the outputs one clock edge later.

Top module: `bldc_commutator`

## Requirements
- R1: With the latched direction forward (0), the Hall bits (hall[2], hall[1], hall[0]) select the source/sink phases as follows. hs_en/ls_en bit 0, 1 and 2 drive phases A, B and C.
  - 110: source C, sink B
  - 100: source C, sink A
  - 101: source B, sink A
  - 001: source B, sink C
  - 011: source A, sink C
  - 010: source A, sink B
- R2: With the latched direction reverse (1), each source/sink pair is selected by the bitwise complement of its forward Hall code.
- R3: Hall codes 000 and 111 are invalid and drive every enable low.
- R4: While stop_req is 1, every enable is low.
- R5: The selected high-side enable is on whatever the carrier. The selected low-side enable is on only while carrier < duty, so a duty of 0 keeps it off.
- R6: oc_flag = 1 turns the low-side enable off in the same update. It stays off in later updates until a cycle in which carrier is 0 and oc_flag is 0.
- R7: The direction is latched from dir_req only in cycles where stop_req is 1. A change of dir_req while running has no effect on the outputs.
- R8: Inputs sampled at one rising edge appear on the outputs after that edge. Synchronous active-low reset clears every enable and sets the direction to forward.
- R9: At most one high-side and at most one low-side enable is on, never on the same phase, and a low-side enable is on only together with a high-side enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hall | input | 3 | Hall comparator bits, bit 2 first position sensor |
| dir_req | input | 1 | Direction request, 0 forward, 1 reverse |
| stop_req | input | 1 | 1 stops the motor, 0 runs it |
| duty | input | DUTY_W | PWM on-time command in carrier counts |
| carrier | input | DUTY_W | Free-running PWM carrier count, wraps to 0 |
| oc_flag | input | 1 | Overcurrent comparator output |
| hs_en | output | 3 | High-side (source) enables, bit 0 = phase A |
| ls_en | output | 3 | Low-side (sink) enables, bit 0 = phase A |

## Verification
The checker watches, on every cycle, that a stop, an invalid Hall code, an expired duty and a pending overcurrent flag each leave the outputs in the required off state. It also checks that the enables never short a phase and that the latched direction holds while running. Only the bench scenarios can show that each of the twelve position codes picks the right phase pair in both directions. The same holds for the overcurrent cut lasting exactly until the carrier wraps, and for a direction request made while running taking effect after the next stop.

// File: rtl/bldc_pkg.sv
// Shared types and the position decode for the commutation block.
// Assumes hall[2] is the first sensor and enable bit 0 is phase A.
package bldc_pkg;

    localparam int PHASES = 3;

    typedef struct packed {
        logic [PHASES-1:0] src;   // high-side selection, one-hot or zero
        logic [PHASES-1:0] snk;   // low-side selection, one-hot or zero
    } drive_t;

    // Forward position map; the two invalid codes select nothing.
    function automatic drive_t decode_fwd(input logic [PHASES-1:0] code);
        drive_t d;
        d = '0;
        case (code)
            3'b110: begin d.src = 3'b100; d.snk = 3'b010; end
            3'b100: begin d.src = 3'b100; d.snk = 3'b001; end
            3'b101: begin d.src = 3'b010; d.snk = 3'b001; end
            3'b001: begin d.src = 3'b010; d.snk = 3'b100; end
            3'b011: begin d.src = 3'b001; d.snk = 3'b100; end
            3'b010: begin d.src = 3'b001; d.snk = 3'b010; end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bldc_dir_latch.sv
// Holds the motor direction. Takes the request only while stopped so the
// rotation sense cannot flip under a spinning motor. Reset gives forward.
module bldc_dir_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic dir_req,
    output logic dir_q
);

    // Update the held direction only in stop mode.
    always_ff @(posedge clk) begin
        if (!rst_n)        dir_q <= 1'b0;
        else if (stop_req) dir_q <= dir_req;
    end

endmodule

// File: rtl/bldc_hall_decoder.sv
// Combinational position decode. Reverse direction reuses the forward map
// on the complemented Hall code. Assumes hall is already synchronised.
module bldc_hall_decoder
    import bldc_pkg::*;
(
    input  logic [PHASES-1:0] hall,
    input  logic              dir_q,
    output drive_t            drv
);

    logic [PHASES-1:0] code;

    // Fold direction into the code, then look up the phase pair.
    always_comb begin
        code = dir_q ? ~hall : hall;
        drv  = decode_fwd(code);
    end

endmodule

// File: rtl/bldc_pwm_chopper.sv
// Low-side chop gate: on while the carrier is below the duty command,
// cut at once by overcurrent and held off until the carrier wraps to 0.
// Assumes the carrier counts up and wraps through 0 every period.
module bldc_pwm_chopper #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty,
    input  logic [DUTY_W-1:0] carrier,
    input  logic              oc_flag,
    output logic              sink_ok
);

    localparam logic [DUTY_W-1:0] WRAP = '0;

    logic oc_block;
    logic at_wrap;

    // Remember an overcurrent event until the next period starts.
    always_ff @(posedge clk) begin
        if (!rst_n)            oc_block <= 1'b0;
        else if (oc_flag)      oc_block <= 1'b1;
        else if (at_wrap)      oc_block <= 1'b0;
    end

    // Gate the sink from duty compare and the overcurrent state.
    always_comb begin
        at_wrap = (carrier == WRAP);
        sink_ok = (carrier < duty) && !oc_flag && (!oc_block || at_wrap);
    end

endmodule

// File: rtl/bldc_commutator.sv
// Top of the commutation and PWM gate. Combines direction latch, position
// decode and chopper, then registers the six switch enables.
// Assumes all inputs are synchronous to clk.
module bldc_commutator
    import bldc_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        hall,
    input  logic              dir_req,
    input  logic              stop_req,
    input  logic [DUTY_W-1:0] duty,
    input  logic [DUTY_W-1:0] carrier,
    input  logic              oc_flag,
    output logic [2:0]        hs_en,
    output logic [2:0]        ls_en
);

    logic   dir_q;
    drive_t drv;
    logic   sink_ok;

    bldc_dir_latch i_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_req (stop_req),
        .dir_req  (dir_req),
        .dir_q    (dir_q)
    );

    bldc_hall_decoder i_dec (
        .hall  (hall),
        .dir_q (dir_q),
        .drv   (drv)
    );

    bldc_pwm_chopper #(.DUTY_W(DUTY_W)) i_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .duty    (duty),
        .carrier (carrier),
        .oc_flag (oc_flag),
        .sink_ok (sink_ok)
    );

    // Register the enables; stop forces all switches off.
    always_ff @(posedge clk) begin
        if (!rst_n || stop_req) begin
            hs_en <= '0;
            ls_en <= '0;
        end else begin
            hs_en <= drv.src;
            ls_en <= sink_ok ? drv.snk : '0;
        end
    end

endmodule

// File: rtl/bldc_commutator_checker.sv
// Cycle-by-cycle properties of the commutation block, bound to its top.
module bldc_commutator_checker #(
    parameter int DUTY_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        hall,
    input logic              stop_req,
    input logic [DUTY_W-1:0] duty,
    input logic [DUTY_W-1:0] carrier,
    input logic              oc_flag,
    input logic              dir_q,
    input logic [2:0]        hs_en,
    input logic [2:0]        ls_en
);

    p_stop_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_req) |-> (hs_en == 3'b000 && ls_en == 3'b000));

    p_bad_hall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hall) == 3'b000 || $past(hall) == 3'b111)
        |-> (hs_en == 3'b000 && ls_en == 3'b000));

    p_duty_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(carrier) >= $past(duty)) |-> (ls_en == 3'b000));

    p_oc_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(oc_flag) |-> (ls_en == 3'b000));

    p_dir_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_req |=> $stable(dir_q));

    p_one_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hs_en) && $onehot0(ls_en));

    p_no_short_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en & ls_en) == 3'b000);

    p_sink_needs_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_en != 3'b000) |-> (hs_en != 3'b000));

endmodule

bind bldc_commutator bldc_commutator_checker #(.DUTY_W(DUTY_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hall     (hall),
    .stop_req (stop_req),
    .duty     (duty),
    .carrier  (carrier),
    .oc_flag  (oc_flag),
    .dir_q    (dir_q),
    .hs_en    (hs_en),
    .ls_en    (ls_en)
);

// File: tb/test_bldc_commutator.sv
module test_bldc_commutator;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall = 3'b000;
    logic       dir_req = 1'b0;
    logic       stop_req = 1'b1;
    logic [7:0] duty = 8'd0;
    logic [7:0] carrier = 8'd0;
    logic       oc_flag = 1'b0;
    logic [2:0] hs_en;
    logic [2:0] ls_en;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bldc_commutator i_bldc_commutator (
        .clk(clk), .rst_n(rst_n), .hall(hall), .dir_req(dir_req),
        .stop_req(stop_req), .duty(duty), .carrier(carrier),
        .oc_flag(oc_flag), .hs_en(hs_en), .ls_en(ls_en)
    );

    // {hall, dir, expected hs, expected ls}
    localparam logic [9:0] VEC [12] = '{
        {3'b110, 1'b0, 3'b100, 3'b010},
        {3'b100, 1'b0, 3'b100, 3'b001},
        {3'b101, 1'b0, 3'b010, 3'b001},
        {3'b001, 1'b0, 3'b010, 3'b100},
        {3'b011, 1'b0, 3'b001, 3'b100},
        {3'b010, 1'b0, 3'b001, 3'b010},
        {3'b001, 1'b1, 3'b100, 3'b010},
        {3'b011, 1'b1, 3'b100, 3'b001},
        {3'b010, 1'b1, 3'b010, 3'b001},
        {3'b110, 1'b1, 3'b010, 3'b100},
        {3'b100, 1'b1, 3'b001, 3'b100},
        {3'b101, 1'b1, 3'b001, 3'b010}
    };

    task automatic chk(input string req, input logic [2:0] eh, input logic [2:0] el);
        n_chk++;
        if (hs_en !== eh || ls_en !== el) begin
            n_bad++;
            $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b", req, hs_en, ls_en, eh, el);
        end
    endtask

    // Drive at the falling edge, then sample just after the next rising edge.
    task automatic step(input logic [2:0] h, input logic s, input logic [7:0] d,
                        input logic [7:0] c, input logic o);
        @(negedge clk);
        hall = h; stop_req = s; duty = d; carrier = c; oc_flag = o;
        @(posedge clk);
        #1;
    endtask

    task automatic set_dir(input logic d);
        @(negedge clk);
        dir_req = d; stop_req = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report();
    end

    initial begin
        // R8: reset clears enables
        hall = 3'b110; stop_req = 1'b0; duty = 8'hFF;
        repeat (3) @(posedge clk);
        #1 chk("R8 reset", 3'b000, 3'b000);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R8 forward after reset", 3'b100, 3'b010);

        // R1, R2: position table in both directions
        for (int i = 0; i < 12; i++) begin
            set_dir(VEC[i][6]);
            step(VEC[i][9:7], 1'b0, 8'hFF, 8'd0, 1'b0);
            chk(VEC[i][6] ? "R2 reverse map" : "R1 forward map", VEC[i][5:3], VEC[i][2:0]);
        end

        // R3: invalid codes, both directions
        set_dir(1'b0);
        step(3'b000, 1'b0, 8'hFF, 8'd0, 1'b0); chk("R3 code 000 fwd", 3'b000, 3'b000);
        step(3'b111, 1'b0, 8'hFF, 8'd0, 1'b0); chk("R3 code 111 fwd", 3'b000, 3'b000);
        set_dir(1'b1);
        step(3'b000, 1'b0, 8'hFF, 8'd0, 1'b0); chk("R3 code 000 rev", 3'b000, 3'b000);
        step(3'b111, 1'b0, 8'hFF, 8'd0, 1'b0); chk("R3 code 111 rev", 3'b000, 3'b000);
        set_dir(1'b0);

        // R4: stop turns everything off
        step(3'b101, 1'b0, 8'hFF, 8'd0, 1'b0); chk("R4 running", 3'b010, 3'b001);
        step(3'b101, 1'b1, 8'hFF, 8'd0, 1'b0); chk("R4 stopped", 3'b000, 3'b000);

        // R8: output holds until the edge
        step(3'b101, 1'b0, 8'hFF, 8'd0, 1'b0);
        @(negedge clk); hall = 3'b011; #1;
        chk("R8 no change before edge", 3'b010, 3'b001);
        @(posedge clk); #1;
        chk("R8 change after edge", 3'b001, 3'b100);

        // R5: duty compare on sink only
        step(3'b011, 1'b0, 8'd100, 8'd99, 1'b0);  chk("R5 below duty", 3'b001, 3'b100);
        step(3'b011, 1'b0, 8'd100, 8'd100, 1'b0); chk("R5 at duty", 3'b001, 3'b000);
        step(3'b011, 1'b0, 8'd100, 8'd255, 1'b0); chk("R5 above duty", 3'b001, 3'b000);
        step(3'b011, 1'b0, 8'd0, 8'd0, 1'b0);     chk("R5 zero duty", 3'b001, 3'b000);

        // R6: overcurrent cut held until wrap
        step(3'b011, 1'b0, 8'd100, 8'd10, 1'b0); chk("R6 before flag", 3'b001, 3'b100);
        step(3'b011, 1'b0, 8'd100, 8'd11, 1'b1); chk("R6 flag cut", 3'b001, 3'b000);
        step(3'b011, 1'b0, 8'd100, 8'd20, 1'b0); chk("R6 held off", 3'b001, 3'b000);
        step(3'b011, 1'b0, 8'd100, 8'd0, 1'b1);  chk("R6 flag at wrap", 3'b001, 3'b000);
        step(3'b011, 1'b0, 8'd100, 8'd1, 1'b0);  chk("R6 held past wrap", 3'b001, 3'b000);
        step(3'b011, 1'b0, 8'd100, 8'd0, 1'b0);  chk("R6 release at wrap", 3'b001, 3'b100);
        step(3'b011, 1'b0, 8'd100, 8'd5, 1'b0);  chk("R6 stays released", 3'b001, 3'b100);

        // R7: direction request while running is ignored
        step(3'b110, 1'b0, 8'hFF, 8'd0, 1'b0);
        @(negedge clk) dir_req = 1'b1;
        @(posedge clk); #1;
        chk("R7 ignored while running", 3'b100, 3'b010);
        step(3'b110, 1'b0, 8'hFF, 8'd0, 1'b0);
        chk("R7 still forward", 3'b100, 3'b010);
        step(3'b110, 1'b1, 8'hFF, 8'd0, 1'b0);
        step(3'b110, 1'b0, 8'hFF, 8'd0, 1'b0);
        chk("R7 taken after stop", 3'b010, 3'b100);

        // R9: one pattern with all features active
        step(3'b010, 1'b0, 8'd50, 8'd49, 1'b0);
        chk("R9 single pair", 3'b010, 3'b001);

        report();
    end

endmodule